// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles, using one adder only as wide as the multiplicand. A one-cycle request captures both operands. The multiplicand is kept in its own register. The multiplier goes into the low part of a single accumulation register whose high part starts at zero.

On every step the block looks at bit 0 of that register. When the bit is 1, the multiplicand is added into the high part. The whole register then moves right by one place, and the adder's carry enters at the top. Each shift discards a multiplier bit that has already been used, and the growing partial product takes over the space it leaves.

With the default 4-bit operands the operation takes four steps and gives an 8-bit product. The result stays on the output until the next request is accepted.

Top module: `shmul_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: When `start` is high while `busy_o` is 0, the next clock edge loads the product register with `{4'b0000, mplier_i}` (the multiplier in bits 3:0, zeros in bits 7:4), captures `mcand_i`, and raises `busy_o`.
- R3: On each step, if bit 0 of the product register is 0, the register shifts right by one and a 0 enters bit 7. If bit 0 is 1, the 5-bit sum of bits 7:4 and the multiplicand replaces bits 7:3, and bits 3:1 move down to bits 2:0. For multiplicand 2 and multiplier 11, the values after each step are 0x15, 0x1A, 0x0D and 0x16.
- R4: The carry out of the 4-bit add lands in bit 7 in the same step, so no overflow is lost. For example, 15 x 15 gives 225.
- R5: `done_o` is high for exactly one cycle. It rises four clock edges after the load edge.
- R6: When `done_o` is high, `product_o` equals `mcand_i * mplier_i` as captured at load, for every pair of 4-bit operands.
- R7: While `busy_o` is 1, `start` is ignored. Neither the captured operands, nor the result, nor the time at which `done_o` rises are changed by it.
- R8: While idle and with `start` low, `product_o` holds its value. Operand inputs that change without `start` have no effect.
- R9: `busy_o` falls in the same cycle that `done_o` rises, so a new request may be given while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; taken only while idle |
| mcand_i | input | 4 | Multiplicand operand |
| mplier_i | input | 4 | Multiplier operand |
| busy_o | output | 1 | High from the load edge until the last step |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 8 | Product register contents; the result once done |

## Verification
The loaded value is due one clock edge after the accepted `start`, and each step's value one edge after the one before it. `done_o` and the final product are due on the fourth edge after the load. The bench drives and samples on falling edges and counts rising edges between samples, so each check reads the output in exactly the cycle its requirement names. It also checks that `done_o` is still low in the three cycles before that and low again one cycle later. The hold and ignore checks sample the cycle right after the stray stimulus, before any new request.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

    // Default operand widths for the block.
    localparam int unsigned DEF_MCAND_W = 4;
    localparam int unsigned DEF_MPLIER_W = 4;

    // Sequencer state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } shmul_state_e;

    // Control word from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // capture operands, clear the high part
        logic step;   // one test/add/shift iteration
    } shmul_ctl_t;

    // One-bit full adder, sum output.
    function automatic logic fa_sum(input logic a, input logic b, input logic ci);
        return a ^ b ^ ci;
    endfunction

    // One-bit full adder, carry output.
    function automatic logic fa_carry(input logic a, input logic b, input logic ci);
        return (a & b) | (a & ci) | (b & ci);
    endfunction

    // Width of a step counter for a given number of steps.
    function automatic int unsigned cnt_width(input int unsigned steps);
        return (steps > 1) ? $clog2(steps) : 1;
    endfunction

endpackage

// File: rtl/shmul_adder.sv
module shmul_adder #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    import shmul_pkg::*;

    logic [W:0] carry;

    assign carry[0] = 1'b0;

    // Ripple chain of full adders, one per bit of the multiplicand width.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]   = fa_sum(a_i[i], b_i[i], carry[i]);
        assign carry[i+1] = fa_carry(a_i[i], b_i[i], carry[i]);
    end

    assign cout_o = carry[W];

endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl #(
    parameter int unsigned STEPS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output shmul_pkg::shmul_ctl_t ctl_o,
    output logic                  busy_o,
    output logic                  done_o
);
    import shmul_pkg::*;

    localparam int unsigned CW = cnt_width(STEPS);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    shmul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done_q, done_d;
    logic          last_step;

    assign last_step = (cnt_q == LAST);

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        done_d     = 1'b0;
        ctl_o.load = 1'b0;
        ctl_o.step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl_o.load = 1'b1;
                    cnt_d      = '0;
                    state_d    = ST_RUN;
                end
            end
            ST_RUN: begin
                // start is not looked at here: requests during a run are dropped
                ctl_o.step = 1'b1;
                if (last_step) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    assign busy_o = (state_q == ST_RUN);
    assign done_o = done_q;

endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath #(
    parameter int unsigned MCAND_W  = 4,
    parameter int unsigned MPLIER_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  shmul_pkg::shmul_ctl_t         ctl_i,
    input  logic [MCAND_W-1:0]            mcand_i,
    input  logic [MPLIER_W-1:0]           mplier_i,
    output logic [MCAND_W+MPLIER_W-1:0]   prod_o,
    output logic [MCAND_W-1:0]            mcand_o
);
    import shmul_pkg::*;

    localparam int unsigned PW = MCAND_W + MPLIER_W;

    logic [PW-1:0]      prod_q, prod_d;
    logic [MCAND_W-1:0] mcand_q;
    logic [MCAND_W-1:0] hi_part;
    logic [MCAND_W-1:0] add_sum;
    logic               add_cout;
    logic               test_bit;

    assign hi_part  = prod_q[PW-1:MPLIER_W];
    assign test_bit = prod_q[0];

    shmul_adder #(.W(MCAND_W)) adder_i (
        .a_i    (hi_part),
        .b_i    (mcand_q),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    // Test bit 0; add into the high part when set; shift right with carry at the top.
    always_comb begin
        prod_d = prod_q;
        if (ctl_i.load) begin
            prod_d = {{MCAND_W{1'b0}}, mplier_i};
        end else if (ctl_i.step) begin
            if (test_bit) begin
                prod_d = {add_cout, add_sum, prod_q[MPLIER_W-1:1]};
            end else begin
                prod_d = {1'b0, prod_q[PW-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            mcand_q <= '0;
        end else begin
            prod_q <= prod_d;
            if (ctl_i.load) begin
                mcand_q <= mcand_i;
            end
        end
    end

    assign prod_o  = prod_q;
    assign mcand_o = mcand_q;

endmodule

// File: rtl/shmul_top.sv
module shmul_top #(
    parameter int unsigned MCAND_W  = shmul_pkg::DEF_MCAND_W,
    parameter int unsigned MPLIER_W = shmul_pkg::DEF_MPLIER_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [MCAND_W-1:0]          mcand_i,
    input  logic [MPLIER_W-1:0]         mplier_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [MCAND_W+MPLIER_W-1:0] product_o
);
    import shmul_pkg::*;

    shmul_ctl_t         ctl;
    logic [MCAND_W-1:0] mcand_q;

    shmul_ctrl #(.STEPS(MPLIER_W)) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ctl_o  (ctl),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    shmul_datapath #(.MCAND_W(MCAND_W), .MPLIER_W(MPLIER_W)) dp_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .prod_o   (product_o),
        .mcand_o  (mcand_q)
    );

endmodule

// File: rtl/shmul_chk.sv
module shmul_chk #(
    parameter int unsigned MCAND_W  = 4,
    parameter int unsigned MPLIER_W = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        start,
    input logic [MPLIER_W-1:0]         mplier_i,
    input logic                        busy_o,
    input logic                        done_o,
    input logic [MCAND_W+MPLIER_W-1:0] product_o,
    input logic [MCAND_W-1:0]          mcand_q
);
    localparam int unsigned PW = MCAND_W + MPLIER_W;

    // Counts step edges since the load; compared against the step count.
    logic [31:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (start && !busy_o) begin
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_o) |=> (busy_o && product_o == {{MCAND_W{1'b0}}, $past(mplier_i)}));

    assert_shift_only_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !product_o[0]) |=> (product_o == ($past(product_o) >> 1)));

    assert_add_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && product_o[0]) |=>
        (product_o[PW-1:MPLIER_W-1] ==
         ({1'b0, $past(product_o[PW-1:MPLIER_W])} + {1'b0, $past(mcand_q)})));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_timing_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_cnt == 32'(MPLIER_W)));

    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(mcand_q));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start) |=> $stable(product_o));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

bind shmul_top shmul_chk #(.MCAND_W(MCAND_W), .MPLIER_W(MPLIER_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o),
    .mcand_q   (mcand_q)
);

// File: tb/shmul_top_tb_top.sv
module shmul_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] mcand;
    logic [3:0] mplier;
    logic       busy;
    logic       done;
    logic [7:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 4 ns period

    shmul_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mcand_i   (mcand),
        .mplier_i  (mplier),
        .busy_o    (busy),
        .done_o    (done),
        .product_o (product)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One full operation; trace checks each step, poke requests during the run.
    task automatic run_mul(input logic [3:0] a, input logic [3:0] b,
                           input bit trace, input bit poke);
        logic [7:0] model;
        logic [4:0] s;
        @(negedge clk);
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        @(negedge clk);
        start = 1'b0;
        model = {4'b0000, b};
        check(product == model, "R2 load value", product, model);
        check(busy == 1'b1, "R2 busy after load", busy, 1);
        for (int k = 1; k <= 4; k++) begin
            if (poke && k == 2) begin
                start  = 1'b1;
                mcand  = ~a;
                mplier = ~b;
            end
            // step model from R3
            if (model[0]) begin
                s     = {1'b0, model[7:4]} + {1'b0, a};
                model = {s, model[3:1]};
            end else begin
                model = model >> 1;
            end
            @(negedge clk);
            start = 1'b0;
            if (trace) check(product == model, "R3 step value", product, model);
            if (k < 4) begin
                check(done == 1'b0, "R5 done early", done, 0);
            end else begin
                check(done == 1'b1, "R5 done on fourth step", done, 1);
                check(busy == 1'b0, "R9 busy low with done", busy, 0);
                check(product == 8'(a * b), poke ? "R7 result with ignored start" : "R6 product",
                      product, a * b);
            end
        end
        mcand  = a ^ 4'h5;
        mplier = b ^ 4'hA;
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", done, 0);
        check(product == 8'(a * b), "R8 hold while idle", product, a * b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R5: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst    = 1'b1;
        start  = 1'b0;
        mcand  = 4'h0;
        mplier = 4'h0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(product == 8'h00, "R1 product in reset", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check(product == 8'h00 && !busy, "R1 idle after reset", product, 0);

        // worked example with every step traced (R3)
        run_mul(4'd2, 4'd11, 1'b1, 1'b0);
        // carry into the top bit (R4)
        run_mul(4'd15, 4'd15, 1'b1, 1'b0);
        check(product == 8'd225, "R4 carry kept", product, 225);
        // requests during a run are dropped (R7)
        run_mul(4'd9, 4'd6, 1'b0, 1'b1);
        run_mul(4'd15, 4'd1, 1'b1, 1'b1);

        // every operand pair (R6), with step tracing
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_mul(4'(a), 4'(b), 1'b1, 1'b0);
            end
        end

        // back-to-back: new request in the done cycle (R9)
        @(negedge clk);
        start  = 1'b1;
        mcand  = 4'd7;
        mplier = 4'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(done == 1'b1, "R9 first done", done, 1);
        start  = 1'b1;
        mcand  = 4'd13;
        mplier = 4'd12;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && product == 8'h0C, "R9 restart in done cycle", product, 8'h0C);
        repeat (4) @(negedge clk);
        check(done == 1'b1 && product == 8'd156, "R9 second result", product, 156);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule